// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This block controls an entry lock. The secret is a short binary code, three bits by default, held in a register that can be rewritten. The user enters the attempt one bit at a time. For each bit, the user sets the key switch and then presses the enter button. The block compares each entered bit with the stored bit in the same position. After the last bit it raises either the unlock output or the error output.

A wrong bit gives no sign at once. After a mismatch the sequencer moves onto a separate chain of "miss" states. That chain takes the same number of enter presses as the success path, so the error indication always comes after the final bit. The attempt therefore never shows which position was wrong. The outcome holds until the next reset, and a new attempt always begins from reset.

Top module: `serial_combo_lock`

## Requirements
- R1: A synchronous reset clears `unlock` and `error` to 0, returns the sequencer to its start state, and clears the stored code to all zeros.
- R2: `enter` is edge-detected. One low-to-high transition advances exactly one bit, however many cycles `enter` stays high. If `enter` is high when reset is released, that counts as no press until `enter` has gone low and risen again.
- R3: The key bit is sampled in the cycle where `enter` is first seen high. The n-th press (n = 0, 1, 2) is compared with `code_in`-loaded bit n, so bit 0 is entered first.
- R4: If all entered bits equal the stored code, `unlock` goes to 1 on the clock edge that samples the last press, and `error` stays 0.
- R5: If any entered bit differs, `error` goes to 1 only on the clock edge that samples the last press. Both outputs stay 0 after every earlier press, whether that press matched or not.
- R6: Once `unlock` or `error` is 1, it stays 1 until reset. Further presses, key values and load requests do not change either output.
- R7: `unlock` and `error` are never 1 at the same time.
- R8: `code_load` writes `code_in` into the stored code only in the start state, and only in a cycle with no enter press. A load request at any other time is ignored.
- R9: A reset in the middle of an attempt discards the bits already entered. The next attempt needs the full number of presses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter | input | 1 | Enter button level; rising edge confirms one bit |
| key_bit | input | 1 | Key switch value for the current bit |
| code_load | input | 1 | Request to store `code_in` as the secret |
| code_in | input | CODE_LEN | New secret; bit 0 is checked first |
| unlock | output | 1 | Attempt matched the secret (held until reset) |
| error | output | 1 | Attempt had at least one wrong bit (held until reset) |

## Verification
The bench tries every entered pattern against every stored code. After each press it checks that the outputs stay quiet until the final bit. If the error were raised early, the bench sees an output during the first or second press, and a design that swapped bit order flags the wrong patterns. The bench holds `enter` high for many cycles, and also holds it high across reset release. A level-sensitive design would take several bits from one press, or take a phantom bit, and would give the wrong outcome. Load requests that arrive after the first press, or in the same cycle as a press, must leave the secret unchanged. Presses after the outcome must not flip or clear it, and a reset in mid-attempt must force a full new sequence.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    typedef enum logic [2:0] {
        PH_START = 3'd0,
        PH_MATCH = 3'd1,
        PH_MISS  = 3'd2,
        PH_OPEN  = 3'd3,
        PH_ALARM = 3'd4
    } phase_e;

    function automatic int unsigned idx_width(input int unsigned len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

    function automatic logic phase_collecting(input phase_e ph);
        return (ph == PH_START) || (ph == PH_MATCH) || (ph == PH_MISS);
    endfunction

    function automatic phase_e next_phase(input phase_e cur,
                                          input logic   press,
                                          input logic   hit,
                                          input logic   last);
        phase_e nxt;
        nxt = cur;
        if (press) begin
            unique case (cur)
                PH_START, PH_MATCH: begin
                    if (last) nxt = hit ? PH_OPEN : PH_ALARM;
                    else      nxt = hit ? PH_MATCH : PH_MISS;
                end
                PH_MISS: nxt = last ? PH_ALARM : PH_MISS;
                default: nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/combo_lock_edge.sv
module combo_lock_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/combo_lock_code.sv
module combo_lock_code #(
    parameter int unsigned CODE_LEN = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CODE_LEN-1:0] wr_data,
    output logic [CODE_LEN-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst)        code_q <= '0;
        else if (wr_en) code_q <= wr_data;
    end
endmodule

// File: rtl/combo_lock_seq.sv
module combo_lock_seq
    import combo_lock_pkg::*;
#(
    parameter int unsigned CODE_LEN = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                press,
    input  logic                key_bit,
    input  logic [CODE_LEN-1:0] code_q,
    output logic                in_start,
    output logic                unlock,
    output logic                error
);
    localparam int unsigned IDX_W = idx_width(CODE_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t cur, nxt;
    logic hit, last;

    assign hit  = (key_bit == code_q[cur.idx]);
    assign last = (cur.idx == LAST_IDX);

    always_comb begin
        nxt       = cur;
        nxt.phase = next_phase(cur.phase, press, hit, last);
        if (press && phase_collecting(cur.phase) && !last)
            nxt.idx = cur.idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.phase <= PH_START;
            cur.idx   <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign in_start = (cur.phase == PH_START);
    assign unlock   = (cur.phase == PH_OPEN);
    assign error    = (cur.phase == PH_ALARM);
endmodule

// File: rtl/serial_combo_lock.sv
module serial_combo_lock #(
    parameter int unsigned CODE_LEN = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enter,
    input  logic                key_bit,
    input  logic                code_load,
    input  logic [CODE_LEN-1:0] code_in,
    output logic                unlock,
    output logic                error
);
    logic                press;
    logic                in_start;
    logic                code_wr;
    logic [CODE_LEN-1:0] code_q;

    combo_lock_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (enter),
        .rise  (press)
    );

    assign code_wr = code_load & in_start & ~press;

    combo_lock_code #(.CODE_LEN(CODE_LEN)) u_code (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (code_wr),
        .wr_data (code_in),
        .code_q  (code_q)
    );

    combo_lock_seq #(.CODE_LEN(CODE_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .press    (press),
        .key_bit  (key_bit),
        .code_q   (code_q),
        .in_start (in_start),
        .unlock   (unlock),
        .error    (error)
    );
endmodule

// File: rtl/combo_lock_checker.sv
module combo_lock_checker #(
    parameter int unsigned CODE_LEN = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                enter,
    input logic                in_start,
    input logic [CODE_LEN-1:0] code_q,
    input logic                unlock,
    input logic                error
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!unlock && !error));

    a_r4_unlock_on_press: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> $past(enter));

    a_r5_error_on_press: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> $past(enter));

    a_r6_unlock_sticky: assert property (@(posedge clk) disable iff (rst)
        unlock |=> unlock);

    a_r6_error_sticky: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    a_r8_code_frozen: assert property (@(posedge clk) disable iff (rst)
        !in_start |=> $stable(code_q));
endmodule

bind serial_combo_lock combo_lock_checker #(.CODE_LEN(CODE_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enter    (enter),
    .in_start (in_start),
    .code_q   (code_q),
    .unlock   (unlock),
    .error    (error)
);

// File: tb/test_serial_combo_lock.sv
`timescale 1ns/1ps
module test_serial_combo_lock;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enter = 1'b0;
    logic         key_bit = 1'b0;
    logic         code_load = 1'b0;
    logic [N-1:0] code_in = '0;
    logic         unlock, error;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    serial_combo_lock #(.CODE_LEN(N)) i_serial_combo_lock (
        .clk(clk), .rst(rst), .enter(enter), .key_bit(key_bit),
        .code_load(code_load), .code_in(code_in),
        .unlock(unlock), .error(error)
    );

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if ({unlock, error} !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, {unlock, error}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [N-1:0] c);
        @(negedge clk); code_in = c; code_load = 1'b1;
        @(negedge clk); code_load = 1'b0;
    endtask

    task automatic press(input logic b, input int hold);
        @(negedge clk); key_bit = b; enter = 1'b1;
        repeat (hold) @(negedge clk);
        enter = 1'b0; key_bit = ~b;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, and stored code cleared to zero
        do_reset();
        chk("R1 reset outputs", 2'b00);
        press(1'b0, 1); press(1'b0, 1); press(1'b0, 1);
        chk("R1 cleared code matches 000", 2'b10);

        // R3 R4 R5 R7: every code against every attempt
        for (int c = 0; c < (1 << N); c++) begin
            for (int k = 0; k < (1 << N); k++) begin
                do_reset();
                load(N'(c));
                for (int i = 0; i < N; i++) begin
                    press(k[i], 1);
                    if (i < N - 1) chk("R5 quiet before last bit", 2'b00);
                end
                if (c == k) chk("R4 match unlocks", 2'b10);
                else        chk("R5 mismatch errors late", 2'b01);
                if (unlock && error) chk("R7 exclusive", 2'b00);
            end
        end

        // R2: long hold counts once
        do_reset(); load(3'b101);
        press(1'b1, 7);
        chk("R2 long hold one bit", 2'b00);
        press(1'b0, 4);
        chk("R2 second long hold", 2'b00);
        press(1'b1, 9);
        chk("R2 long holds unlock", 2'b10);

        // R2: enter held across reset release is not a press
        @(negedge clk); rst = 1'b1; enter = 1'b1; key_bit = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); code_in = 3'b111; code_load = 1'b1;
        @(negedge clk); code_load = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 held enter no press", 2'b00);
        enter = 1'b0;
        press(1'b1, 1); press(1'b1, 1); press(1'b1, 1);
        chk("R2 held enter ignored", 2'b10);

        // R8: load after first press ignored
        do_reset(); load(3'b101);
        press(1'b1, 1);
        load(3'b000);
        press(1'b0, 1); press(1'b1, 1);
        chk("R8 late load ignored", 2'b10);

        // R8: load in same cycle as press ignored
        do_reset(); load(3'b011);
        @(negedge clk); code_in = 3'b000; code_load = 1'b1; key_bit = 1'b1; enter = 1'b1;
        @(negedge clk); code_load = 1'b0; enter = 1'b0;
        @(negedge clk);
        press(1'b1, 1); press(1'b0, 1);
        chk("R8 load with press ignored", 2'b10);

        // R6: outcome held against later stimulus
        press(1'b1, 1); press(1'b0, 1);
        load(3'b110);
        chk("R6 unlock held", 2'b10);
        do_reset(); load(3'b010);
        press(1'b1, 1); press(1'b1, 1); press(1'b0, 1);
        chk("R6 error set", 2'b01);
        press(1'b0, 1); press(1'b1, 1); press(1'b0, 1);
        chk("R6 error held", 2'b01);

        // R9: reset mid-attempt discards partial bits
        do_reset(); load(3'b110);
        press(1'b0, 1); press(1'b1, 1);
        do_reset();
        press(1'b0, 1);
        chk("R9 restart needs full sequence", 2'b00);
        press(1'b0, 1);
        chk("R9 still collecting", 2'b00);
        press(1'b0, 1);
        chk("R9 full new attempt", 2'b10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule